// File: doc/BRIEF.md
# Serial PHY Tuning Bit Writer

This block programs tuning bits inside a PHY macro that exposes only a narrow control word. A single request names a PHY lane, a starting tuning address, a value of up to eight bits and how many of those bits to send. The sequencer then walks the bits from the least significant one upward. For each bit it places an incrementing address in the upper byte of the control word and the bit itself in the data position. It then pulses the strobe that belongs to the chosen lane high and back low. The PHY latches one tuning bit on each strobe pulse.

Each of the four steps of a bit (address, data, strobe high, strobe low) holds for a programmable number of clock cycles, so slow PHY control logic can be matched. Some PHY generations expect the whole control word to be zeroed before a transfer, so each request can ask for an optional clearing step. While a transfer runs, `busy` is high and any further request is dropped. A one-cycle `done` pulse marks the end of each transfer. Bit counts above the value width are treated as the value width.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset the control word is all zeros, and `busy` and `done` are both low.
- R2: While bit i of a transfer is being sent, bits 15:8 of the control word hold the start address plus i, modulo 256.
- R3: Bit 7 of the control word carries bit i of the value while bit i is sent, so bits go out least significant first.
- R4: The strobe for lane n is control bit 2*n. Each bit runs four steps in this order: address loaded; data bit set with the strobe low; strobe high; strobe low. Each step lasts L cycles, where L is `phase_len`, or 1 when `phase_len` is 0. The address and data fields do not change while a strobe is high.
- R5: When `req_clear` is set, the whole control word reads zero for L cycles before the first address step.
- R6: `busy` goes high on the cycle after a request with a non-zero count is accepted. It stays high until the transfer ends. A request made while `busy` is high has no effect on the transfer or on the control word.
- R7: A request with a bit count of zero raises `done` on the next cycle, leaves `busy` low and leaves the control word unchanged.
- R8: `done` is high for exactly one cycle. It appears (C+4n)*L cycles after the accepting edge, where C is 1 with clearing and 0 without, and n is the bit count. `busy` falls on that same edge. The control word then keeps its final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_lane | input | 2 | Target PHY lane |
| req_addr | input | 8 | Tuning address of the first bit |
| req_value | input | 8 | Bits to write, LSB first |
| req_count | input | 4 | Number of bits to send |
| req_clear | input | 1 | Zero the control word before the first bit |
| phase_len | input | 4 | Cycles per step, 0 taken as 1 |
| ctrl_word | output | 16 | Control word presented to the PHY |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is a register, so the first effect of an accepted request shows on the cycle right after the accepting edge. After that, the control word changes once every L cycles. The clearing step, if present, comes first, then four steps per bit, and `done` arrives (C+4n)*L cycles after acceptance. The bench turns each request into a cycle-by-cycle list of expected control word, `busy` and `done` values. A monitor then compares one entry per cycle, sampling just after each rising edge, so a step that is one cycle early or late shows up as a mismatch. Requests made while busy push nothing into that list, so any effect they have appears as a mismatch in the entries for the running transfer.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;

  // Step of a bit-serial transfer; IDLE means no transfer is running.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CLEAR  = 3'd1,
    PH_ADDR   = 3'd2,
    PH_DATA   = 3'd3,
    PH_STB_HI = 3'd4,
    PH_STB_LO = 3'd5
  } phase_e;

  // Position of the serial data bit inside the control word.
  localparam int DATA_POS = 7;
  // Lowest bit of the address field inside the control word.
  localparam int ADDR_LSB = 8;

endpackage

// File: rtl/tune_rst_sync.sv
module tune_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/tune_step_timer.sv
module tune_step_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             expire
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  // A zero length behaves as one cycle per step.
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = (len == '0) ? '0 : len - LEN_W'(1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/tune_bit_seq.sv
module tune_bit_seq
  import phy_tune_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  parameter int LEN_W  = 4,
  parameter int IDX_W  = 3,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [VAL_W-1:0]  req_value,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_clear,
  input  logic [LEN_W-1:0]  phase_len,
  input  logic              expire,
  output phase_e            phase_d,
  output logic              enter,
  output logic [LANE_W-1:0] lane_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic              bit_d,
  output logic [LEN_W-1:0]  len_d,
  output logic              busy,
  output logic              done
);

  phase_e             phase_q;
  logic [IDX_W-1:0]   idx_q,  idx_d;
  logic [LANE_W-1:0]  lane_q;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [VAL_W-1:0]   val_q,  val_d;
  logic [CNT_W-1:0]   cnt_q,  cnt_d;
  logic [LEN_W-1:0]   len_q;
  logic               done_q, done_d;
  logic               accept;
  logic               last_bit;
  logic [CNT_W-1:0]   eff_cnt;

  assign accept   = (phase_q == PH_IDLE) && req_valid;
  assign eff_cnt  = (req_count > CNT_W'(VAL_W)) ? CNT_W'(VAL_W) : req_count;
  assign last_bit = ((CNT_W'(idx_q) + CNT_W'(1)) == cnt_q);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    lane_d  = lane_q;
    base_d  = base_q;
    val_d   = val_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    done_d  = 1'b0;
    enter   = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (accept) begin
        lane_d = req_lane;
        base_d = req_addr;
        val_d  = req_value;
        cnt_d  = eff_cnt;
        len_d  = phase_len;
        idx_d  = '0;
        if (eff_cnt == '0) begin
          done_d = 1'b1;
        end else begin
          phase_d = req_clear ? PH_CLEAR : PH_ADDR;
          enter   = 1'b1;
        end
      end
    end else if (expire) begin
      enter = 1'b1;
      unique case (phase_q)
        PH_CLEAR:  phase_d = PH_ADDR;
        PH_ADDR:   phase_d = PH_DATA;
        PH_DATA:   phase_d = PH_STB_HI;
        PH_STB_HI: phase_d = PH_STB_LO;
        PH_STB_LO: begin
          if (last_bit) begin
            phase_d = PH_IDLE;
            enter   = 1'b0;
            done_d  = 1'b1;
          end else begin
            phase_d = PH_ADDR;
            idx_d   = idx_q + IDX_W'(1);
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  assign addr_d = base_d + ADDR_W'(idx_d);
  assign bit_d  = val_d[idx_d];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      lane_q  <= '0;
      base_q  <= '0;
      val_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      if (accept) begin
        lane_q <= lane_d;
        base_q <= base_d;
        val_q  <= val_d;
        cnt_q  <= cnt_d;
        len_q  <= len_d;
      end
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign done = done_q;

  // R6
  stray_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(lane_q) && $stable(base_q) && $stable(val_q) && $stable(cnt_q)));

  // R7
  zero_count_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_count == '0) |=> (done && !busy));

endmodule

// File: rtl/tune_ctrl_word.sv
module tune_ctrl_word
  import phy_tune_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int ADDR_W    = 8,
  parameter int LANE_W    = 2,
  parameter int WORD_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enter,
  input  phase_e               phase_d,
  input  logic [LANE_W-1:0]    lane_d,
  input  logic [ADDR_W-1:0]    addr_d,
  input  logic                 bit_d,
  output logic [WORD_W-1:0]    word,
  output logic [NUM_LANES-1:0] strb
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] lane_mask;

  // Strobe of lane n lives at control bit 2*n.
  always_comb begin
    lane_mask = '0;
    lane_mask[{lane_d, 1'b0}] = 1'b1;
  end

  always_comb begin
    word_d = word_q;
    if (enter) begin
      unique case (phase_d)
        PH_CLEAR:  word_d = '0;
        PH_ADDR:   word_d[WORD_W-1:ADDR_LSB] = addr_d;
        PH_DATA: begin
          word_d           = word_q & ~lane_mask;
          word_d[DATA_POS] = bit_d;
        end
        PH_STB_HI: word_d = word_q | lane_mask;
        PH_STB_LO: word_d = word_q & ~lane_mask;
        default:   word_d = word_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (enter) begin
      word_q <= word_d;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_strb_tap
    assign strb[g] = word_q[2*g];
  end

  assign word = word_q;

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import phy_tune_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int ADDR_W    = 8,
  parameter int VAL_W     = 8,
  parameter int LEN_W     = 4,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int CNT_W    = $clog2(VAL_W + 1),
  localparam int IDX_W    = (VAL_W > 1) ? $clog2(VAL_W) : 1,
  localparam int WORD_W   = ADDR_W + ADDR_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [VAL_W-1:0]  req_value,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_clear,
  input  logic [LEN_W-1:0]  phase_len,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              busy,
  output logic              done
);

  logic              rst_i_n;
  logic              expire;
  logic              enter;
  phase_e            phase_d;
  logic [LANE_W-1:0] lane_d;
  logic [ADDR_W-1:0] addr_d;
  logic              bit_d;
  logic [LEN_W-1:0]  len_d;
  logic [NUM_LANES-1:0] strb;

  tune_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tune_step_timer #(.LEN_W(LEN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .start  (enter),
    .len    (len_d),
    .expire (expire)
  );

  tune_bit_seq #(
    .VAL_W (VAL_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .LEN_W (LEN_W), .IDX_W (IDX_W),  .LANE_W(LANE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_lane  (req_lane),
    .req_addr  (req_addr),
    .req_value (req_value),
    .req_count (req_count),
    .req_clear (req_clear),
    .phase_len (phase_len),
    .expire    (expire),
    .phase_d   (phase_d),
    .enter     (enter),
    .lane_d    (lane_d),
    .addr_d    (addr_d),
    .bit_d     (bit_d),
    .len_d     (len_d),
    .busy      (busy),
    .done      (done)
  );

  tune_ctrl_word #(
    .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .WORD_W(WORD_W)
  ) u_word (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .enter   (enter),
    .phase_d (phase_d),
    .lane_d  (lane_d),
    .addr_d  (addr_d),
    .bit_d   (bit_d),
    .word    (ctrl_word),
    .strb    (strb)
  );

  // R8
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> (busy || done));

  // R4
  strobe_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|strb) |-> busy);

  // R4
  fields_hold_under_strobe_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|strb) |=> $stable(ctrl_word[WORD_W-1:DATA_POS]));

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> !busy);

endmodule

// File: tb/phy_tune_writer_tb.sv
`timescale 1ns/1ps
module phy_tune_writer_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_lane;
  logic [7:0]  req_addr;
  logic [7:0]  req_value;
  logic [3:0]  req_count;
  logic        req_clear;
  logic [3:0]  phase_len;
  logic [15:0] ctrl_word;
  logic        busy;
  logic        done;

  typedef struct {
    logic [15:0] w;
    logic        b;
    logic        d;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          n_checks;
  int          n_fail;
  logic [15:0] mw;

  phy_tune_writer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane(req_lane),
    .req_addr(req_addr), .req_value(req_value), .req_count(req_count),
    .req_clear(req_clear), .phase_len(phase_len), .ctrl_word(ctrl_word),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic push(input logic [15:0] w, input logic b, input logic d, input string tag, input int reps);
    for (int k = 0; k < reps; k++) begin
      exp_t e;
      e.w = w; e.b = b; e.d = d; e.tag = tag;
      expq.push_back(e);
    end
  endtask

  // Monitor: one expected entry per cycle, sampled just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        n_checks++;
        if (ctrl_word !== e.w || busy !== e.b || done !== e.d) begin
          n_fail++;
          $display("FAIL %s: word=%h busy=%b done=%b expected word=%h busy=%b done=%b",
                   e.tag, ctrl_word, busy, done, e.w, e.b, e.d);
        end
      end
    end
  end

  // Driver: builds the expected trace from the requirements, then issues the request.
  task automatic send(input int lane, input int addr, input int val, input int n,
                      input int len, input bit clr, input int stray_k);
    int L;
    int nb;
    L  = (len == 0) ? 1 : len;
    nb = (n > 8) ? 8 : n;
    @(negedge clk);
    req_valid = 1'b1; req_lane = 2'(lane); req_addr = 8'(addr);
    req_value = 8'(val); req_count = 4'(n); req_clear = clr; phase_len = 4'(len);
    if (nb == 0) begin
      push(mw, 1'b0, 1'b1, "R7", 1);
      push(mw, 1'b0, 1'b0, "R7", 2);
    end else begin
      if (clr) begin
        mw = '0;
        push(mw, 1'b1, 1'b0, "R5", L);
      end
      for (int i = 0; i < nb; i++) begin
        mw[15:8] = 8'(addr + i);
        push(mw, 1'b1, 1'b0, "R2", L);
        mw[7] = val[i];
        mw[2*lane] = 1'b0;
        push(mw, 1'b1, 1'b0, "R3", L);
        mw[2*lane] = 1'b1;
        push(mw, 1'b1, 1'b0, "R4", L);
        mw[2*lane] = 1'b0;
        push(mw, 1'b1, 1'b0, "R4", L);
      end
      push(mw, 1'b0, 1'b1, "R8", 1);
      push(mw, 1'b0, 1'b0, "R8", 2);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (stray_k > 0) begin
      // R6: a request while busy must leave the trace untouched.
      repeat (stray_k - 1) @(negedge clk);
      req_valid = 1'b1; req_lane = 2'(lane + 1); req_addr = 8'(addr + 8'h40);
      req_value = 8'(~val); req_count = 4'd3; req_clear = ~clr; phase_len = 4'd1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (expq.size() == 0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; mw = '0;
    req_valid = 1'b0; req_lane = '0; req_addr = '0; req_value = '0;
    req_count = '0; req_clear = 1'b0; phase_len = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (ctrl_word !== 16'h0 || busy !== 1'b0 || done !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: word=%h busy=%b done=%b expected word=0000 busy=0 done=0",
               ctrl_word, busy, done);
    end
    send(0, 8'h0c, 8'h01, 1, 1, 1'b0, 0);
    send(1, 8'h20, 8'h14, 5, 1, 1'b1, 0);
    send(2, 8'h2a, 8'h03, 2, 3, 1'b0, 5);
    send(3, 8'h3c, 8'h02, 2, 2, 1'b1, 3);
    send(1, 8'h55, 8'hff, 0, 1, 1'b0, 0);
    send(0, 8'hfe, 8'ha5, 8, 0, 1'b0, 7);
    send(2, 8'h10, 8'h06, 3, 2, 1'b1, 0);
    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule